// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out a processor core's entry into an exception once another part of the core has decided that an exception is to be taken. It accepts one request at a time, of one of four kinds: a normal interrupt, a fast interrupt, an indexed software trap or a break trap. It saves the status register and a return program counter, builds the handler's status word, obtains the handler address and redirects the program counter. Normal interrupts and both traps save state by pushing two 32-bit words through a memory write port. They read the handler address from a relocatable vector table through a memory read port. A fast interrupt writes no memory. It copies the state into two backup registers and takes its handler from a dedicated fast-vector input.

The sequencer takes all of its architectural inputs as live values: the status register, the current and next program counters, the interrupt stack pointer, the table base and the fast vector. It samples them in the cycle a request is accepted. Every result goes back through write-enable strobes that the surrounding core applies to its own registers.

States: `ST_IDLE` (waiting), `ST_PUSH_SR` (status word push), `ST_PUSH_PC` (return PC push), `ST_BACKUP` (fast-path copy to backup registers), `ST_FETCH` (vector table read), `ST_REDIRECT` (one-cycle handler launch). Transitions:
- Idle to fast backup, taken on a fast-interrupt request.
- Idle to status push, taken on any other request.
- Status push to PC push, taken when the write port is ready.
- PC push to fetch, taken when the write port is ready.
- Backup to redirect, taken unconditionally.
- Fetch to redirect, taken when the read port is ready.
- Redirect to idle, taken unconditionally.

Top module: `exc_entry_seq`

## Requirements
- R1: A request (`req_valid`=1) seen while `busy`=0 is accepted. `busy` is 1 from the next cycle through the cycle `pc_load` is 1, and 0 the cycle after. Requests seen while `busy`=1 are ignored and leave every result of the ongoing entry unchanged.
- R2: For `req_kind` 0 (normal interrupt), 2 (indexed trap) and 3 (break trap), the original status word is written to address `isp_in`-4 and then the return PC to `isp_in`-8. In the redirect cycle `isp_wr_en`=1 and `isp_out`=`isp_in`-8.
- R3: For `req_kind` 1 (fast interrupt), no memory write or read is made. `bsr_wr_en` and `bpc_wr_en` pulse together with `bsr_out` equal to the original status word and `bpc_out` equal to the return PC. `isp_wr_en` stays 0, and the handler address is `fvec_in`.
- R4: For interrupts (kinds 0 and 1), the return PC is `pc_cur` when `req_restart`=1 and `pc_next` when `req_restart`=0.
- R5: For traps (kinds 2 and 3), the return PC is always `pc_next`, whatever `req_restart` is.
- R6: The new status word `sr_out` equals the original with bit 20 (processor mode), bit 17 (stack select) and bit 16 (interrupt enable) cleared. For interrupts, bits 27:24 are replaced by `req_level`. For traps, bits 27:24 are kept. All other bits are kept.
- R7: The vector read address is `vbase_in` + 4*`req_index` for kinds 0 and 2, and `vbase_in` for kind 3.
- R8: While `wr_valid` or `rd_valid` is 1 and the matching ready is 0, the request and its address and data hold unchanged. The sequence does not advance until ready is 1.
- R9: The entry ends with a single cycle in which `pc_load`=1 and `sr_wr_en`=1. In that cycle `pc_out` is the fetched table entry (or `fvec_in` for kind 1). At most one of `wr_valid`, `rd_valid`, `bsr_wr_en` and `pc_load` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request |
| req_kind | input | 2 | 0 interrupt, 1 fast interrupt, 2 indexed trap, 3 break trap |
| req_level | input | 4 | Priority level of an accepted interrupt |
| req_index | input | 8 | Vector number (interrupt or indexed trap) |
| req_restart | input | 1 | Interrupted instruction is a restartable string/block operation |
| sr_in | input | 32 | Current status register |
| pc_cur | input | 32 | PC of the current instruction |
| pc_next | input | 32 | PC of the next instruction |
| isp_in | input | 32 | Interrupt stack pointer |
| vbase_in | input | 32 | Vector table base |
| fvec_in | input | 32 | Fast interrupt handler address |
| busy | output | 1 | Entry in progress |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| wr_ready | input | 1 | Stack write accepted |
| rd_valid | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_ready | input | 1 | Vector read data valid |
| rd_data | input | 32 | Vector read data |
| bsr_wr_en | output | 1 | Backup status register write strobe |
| bsr_out | output | 32 | Value for backup status register |
| bpc_wr_en | output | 1 | Backup PC write strobe |
| bpc_out | output | 32 | Value for backup PC |
| sr_wr_en | output | 1 | Status register write strobe |
| sr_out | output | 32 | New status word |
| isp_wr_en | output | 1 | Stack pointer write strobe |
| isp_out | output | 32 | New stack pointer |
| pc_load | output | 1 | PC redirect strobe |
| pc_out | output | 32 | Handler address |

## Verification
The alignment properties assume that the stack pointer and the table base are word aligned. They also assume that the memory ready inputs do not depend on anything beyond the current request. The bench keeps to this: every stack pointer and table base it drives has its two low bits cleared, and ready is drawn at random only in cycles where the matching request is visible. While an entry is in progress, the bench also drives noise requests with fresh random inputs. It then checks that the results still match the first request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        KIND_INT  = 2'd0,
        KIND_FAST = 2'd1,
        KIND_TRAP = 2'd2,
        KIND_BRK  = 2'd3
    } exc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_BACKUP,
        ST_FETCH,
        ST_REDIRECT
    } ent_state_e;

    function automatic logic kind_is_irq(exc_kind_e k);
        return (k == KIND_INT) || (k == KIND_FAST);
    endfunction

endpackage

// File: rtl/exc_sr_xform.sv
module exc_sr_xform
    import exc_entry_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MODE_BIT = 20,
    parameter int STK_BIT  = 17,
    parameter int IEN_BIT  = 16,
    parameter int LVL_LSB  = 24,
    parameter int LVL_W    = 4
) (
    input  logic [DW-1:0]    sr_in,
    input  exc_kind_e        kind,
    input  logic [LVL_W-1:0] level,
    output logic [DW-1:0]    sr_out
);
    localparam logic [DW-1:0] CLR_MASK =
        (DW'(1) << MODE_BIT) | (DW'(1) << STK_BIT) | (DW'(1) << IEN_BIT);

    always_comb begin
        sr_out = sr_in & ~CLR_MASK;
        if (kind_is_irq(kind)) begin
            sr_out[LVL_LSB +: LVL_W] = level;
        end
    end

endmodule

// File: rtl/exc_entry_addr.sv
module exc_entry_addr
    import exc_entry_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  exc_kind_e        kind,
    input  logic [IDX_W-1:0] index,
    input  logic             restart,
    input  logic [AW-1:0]    pc_cur,
    input  logic [AW-1:0]    pc_next,
    input  logic [AW-1:0]    vbase,
    output logic [AW-1:0]    vec_addr,
    output logic [AW-1:0]    ret_pc
);
    localparam int ENT_SH = 2;
    localparam int PAD_W  = AW - IDX_W - ENT_SH;

    logic [AW-1:0] offset;

    always_comb begin
        if (kind == KIND_BRK) begin
            offset = '0;
        end else begin
            offset = {{PAD_W{1'b0}}, index, {ENT_SH{1'b0}}};
        end
        vec_addr = vbase + offset;
        if (kind_is_irq(kind) && restart) begin
            ret_pc = pc_cur;
        end else begin
            ret_pc = pc_next;
        end
    end

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_entry_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  exc_kind_e     req_kind,
    input  logic [DW-1:0] sr_old_in,
    input  logic [DW-1:0] sr_new_in,
    input  logic [DW-1:0] ret_pc_in,
    input  logic [DW-1:0] vec_addr_in,
    input  logic [DW-1:0] isp_in,
    input  logic [DW-1:0] fvec_in,
    output logic          busy,
    output logic          wr_valid,
    output logic [DW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          bsr_wr_en,
    output logic [DW-1:0] bsr_out,
    output logic          bpc_wr_en,
    output logic [DW-1:0] bpc_out,
    output logic          sr_wr_en,
    output logic [DW-1:0] sr_out,
    output logic          isp_wr_en,
    output logic [DW-1:0] isp_out,
    output logic          pc_load,
    output logic [DW-1:0] pc_out
);
    localparam logic [DW-1:0] WORD_STEP = DW'(DW / 8);

    ent_state_e    state_q, state_d;
    exc_kind_e     kind_q;
    logic [DW-1:0] sr_old_q, sr_new_q, pc_sv_q, vaddr_q, sp_q, handler_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = (req_kind == KIND_FAST) ? ST_BACKUP : ST_PUSH_SR;
            ST_PUSH_SR:  if (wr_ready)  state_d = ST_PUSH_PC;
            ST_PUSH_PC:  if (wr_ready)  state_d = ST_FETCH;
            ST_BACKUP:                  state_d = ST_REDIRECT;
            ST_FETCH:    if (rd_ready)  state_d = ST_REDIRECT;
            ST_REDIRECT:                state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_q    <= KIND_INT;
            sr_old_q  <= '0;
            sr_new_q  <= '0;
            pc_sv_q   <= '0;
            vaddr_q   <= '0;
            sp_q      <= '0;
            handler_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q    <= req_kind;
                sr_old_q  <= sr_old_in;
                sr_new_q  <= sr_new_in;
                pc_sv_q   <= ret_pc_in;
                vaddr_q   <= vec_addr_in;
                sp_q      <= isp_in;
                handler_q <= fvec_in;
            end
            if ((state_q == ST_PUSH_SR || state_q == ST_PUSH_PC) && wr_ready) begin
                sp_q <= sp_q - WORD_STEP;
            end
            if (state_q == ST_FETCH && rd_ready) begin
                handler_q <= rd_data;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        wr_valid  = 1'b0;
        wr_addr   = sp_q - WORD_STEP;
        wr_data   = sr_old_q;
        rd_valid  = 1'b0;
        rd_addr   = vaddr_q;
        bsr_wr_en = 1'b0;
        bpc_wr_en = 1'b0;
        sr_wr_en  = 1'b0;
        isp_wr_en = 1'b0;
        pc_load   = 1'b0;
        bsr_out   = sr_old_q;
        bpc_out   = pc_sv_q;
        sr_out    = sr_new_q;
        isp_out   = sp_q;
        pc_out    = handler_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH_SR: wr_valid = 1'b1;
            ST_PUSH_PC: begin
                wr_valid = 1'b1;
                wr_data  = pc_sv_q;
            end
            ST_BACKUP: begin
                bsr_wr_en = 1'b1;
                bpc_wr_en = 1'b1;
            end
            ST_FETCH: rd_valid = 1'b1;
            ST_REDIRECT: begin
                pc_load   = 1'b1;
                sr_wr_en  = 1'b1;
                isp_wr_en = (kind_q != KIND_FAST);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int DW       = 32,
    parameter int IDX_W    = 8,
    parameter int LVL_W    = 4,
    parameter int MODE_BIT = 20,
    parameter int STK_BIT  = 17,
    parameter int IEN_BIT  = 16,
    parameter int LVL_LSB  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [LVL_W-1:0] req_level,
    input  logic [IDX_W-1:0] req_index,
    input  logic             req_restart,
    input  logic [DW-1:0]    sr_in,
    input  logic [DW-1:0]    pc_cur,
    input  logic [DW-1:0]    pc_next,
    input  logic [DW-1:0]    isp_in,
    input  logic [DW-1:0]    vbase_in,
    input  logic [DW-1:0]    fvec_in,
    output logic             busy,
    output logic             wr_valid,
    output logic [DW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    input  logic             wr_ready,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_addr,
    input  logic             rd_ready,
    input  logic [DW-1:0]    rd_data,
    output logic             bsr_wr_en,
    output logic [DW-1:0]    bsr_out,
    output logic             bpc_wr_en,
    output logic [DW-1:0]    bpc_out,
    output logic             sr_wr_en,
    output logic [DW-1:0]    sr_out,
    output logic             isp_wr_en,
    output logic [DW-1:0]    isp_out,
    output logic             pc_load,
    output logic [DW-1:0]    pc_out
);
    exc_kind_e     kind;
    logic [DW-1:0] sr_new, ret_pc, vec_addr;

    assign kind = exc_kind_e'(req_kind);

    exc_sr_xform #(
        .DW(DW), .MODE_BIT(MODE_BIT), .STK_BIT(STK_BIT),
        .IEN_BIT(IEN_BIT), .LVL_LSB(LVL_LSB), .LVL_W(LVL_W)
    ) u_xform (
        .sr_in  (sr_in),
        .kind   (kind),
        .level  (req_level),
        .sr_out (sr_new)
    );

    exc_entry_addr #(.AW(DW), .IDX_W(IDX_W)) u_addr (
        .kind     (kind),
        .index    (req_index),
        .restart  (req_restart),
        .pc_cur   (pc_cur),
        .pc_next  (pc_next),
        .vbase    (vbase_in),
        .vec_addr (vec_addr),
        .ret_pc   (ret_pc)
    );

    exc_entry_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (kind),
        .sr_old_in   (sr_in),
        .sr_new_in   (sr_new),
        .ret_pc_in   (ret_pc),
        .vec_addr_in (vec_addr),
        .isp_in      (isp_in),
        .fvec_in     (fvec_in),
        .busy        (busy),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .rd_valid    (rd_valid),
        .rd_addr     (rd_addr),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .bsr_wr_en   (bsr_wr_en),
        .bsr_out     (bsr_out),
        .bpc_wr_en   (bpc_wr_en),
        .bpc_out     (bpc_out),
        .sr_wr_en    (sr_wr_en),
        .sr_out      (sr_out),
        .isp_wr_en   (isp_wr_en),
        .isp_out     (isp_out),
        .pc_load     (pc_load),
        .pc_out      (pc_out)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int DW       = 32,
    parameter int MODE_BIT = 20,
    parameter int STK_BIT  = 17,
    parameter int IEN_BIT  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [DW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [DW-1:0] rd_addr,
    input logic          bsr_wr_en,
    input logic          sr_wr_en,
    input logic [DW-1:0] sr_out,
    input logic          pc_load
);
    localparam logic [DW-1:0] CLR_MASK =
        (DW'(1) << MODE_BIT) | (DW'(1) << STK_BIT) | (DW'(1) << IEN_BIT);
    localparam logic [DW-1:0] LOW2 = DW'(3);

    a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    a_r2_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_addr & LOW2) == '0));

    a_r7_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_addr & LOW2) == '0));

    a_r3_backup_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr_en |-> (!wr_valid && !rd_valid && busy));

    a_r6_sr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en |-> ((sr_out & CLR_MASK) == '0));

    a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, rd_valid, bsr_wr_en, pc_load}));

    a_r9_sr_with_pc: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (sr_wr_en && busy));

endmodule

bind exc_entry_seq exc_entry_chk #(
    .DW(DW), .MODE_BIT(MODE_BIT), .STK_BIT(STK_BIT), .IEN_BIT(IEN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .bsr_wr_en (bsr_wr_en),
    .sr_wr_en  (sr_wr_en),
    .sr_out    (sr_out),
    .pc_load   (pc_load)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [3:0]  req_level = '0;
    logic [7:0]  req_index = '0;
    logic        req_restart = 1'b0;
    logic [31:0] sr_in = '0, pc_cur = '0, pc_next = '0, isp_in = '0, vbase_in = '0, fvec_in = '0;
    logic        wr_ready = 1'b0, rd_ready = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, wr_valid, rd_valid, bsr_wr_en, bpc_wr_en, sr_wr_en, isp_wr_en, pc_load;
    logic [31:0] wr_addr, wr_data, rd_addr, bsr_out, bpc_out, sr_out, isp_out, pc_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_level(req_level), .req_index(req_index), .req_restart(req_restart),
        .sr_in(sr_in), .pc_cur(pc_cur), .pc_next(pc_next), .isp_in(isp_in),
        .vbase_in(vbase_in), .fvec_in(fvec_in), .busy(busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .bsr_wr_en(bsr_wr_en), .bsr_out(bsr_out), .bpc_wr_en(bpc_wr_en), .bpc_out(bpc_out),
        .sr_wr_en(sr_wr_en), .sr_out(sr_out), .isp_wr_en(isp_wr_en), .isp_out(isp_out),
        .pc_load(pc_load), .pc_out(pc_out)
    );

    function automatic logic [31:0] vec_of(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] exp_sr(logic [31:0] s, logic [1:0] k, logic [3:0] lvl);
        logic [31:0] r;
        r = s & ~((32'd1 << 20) | (32'd1 << 17) | (32'd1 << 16));
        if (k < 2'd2) r[27:24] = lvl;
        return r;
    endfunction

    function automatic logic [31:0] exp_ret(logic [1:0] k, logic rs, logic [31:0] cur, logic [31:0] nxt);
        return (k < 2'd2 && rs) ? cur : nxt;
    endfunction

    function automatic logic [31:0] exp_vaddr(logic [1:0] k, logic [31:0] b, logic [7:0] ix);
        return (k == 2'd3) ? b : b + {22'd0, ix, 2'b00};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_one(logic [1:0] k, logic [3:0] lvl, logic [7:0] ix, logic rs,
                           logic [31:0] s, logic [31:0] cur, logic [31:0] nxt,
                           logic [31:0] sp, logic [31:0] vb, logic [31:0] fv, bit noise);
        logic [31:0] wa [4];
        logic [31:0] wd [4];
        int wn = 0;
        int rn = 0;
        logic [31:0] ra = '0;
        int bn = 0;
        logic [31:0] b_sr = '0, b_pc = '0;
        logic [31:0] f_sr = '0, f_isp = '0, f_pc = '0;
        logic f_ispen = 1'b0;
        bit seen = 1'b0;
        bit bsy_bad = 1'b0;
        logic [31:0] rpc;
        rpc = exp_ret(k, rs, cur, nxt);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_level = lvl; req_index = ix; req_restart = rs;
        sr_in = s; pc_cur = cur; pc_next = nxt; isp_in = sp; vbase_in = vb; fvec_in = fv;
        for (int c = 0; c < 60 && !seen; c++) begin
            @(negedge clk);
            if (!busy) bsy_bad = 1'b1;
            wr_ready = wr_valid ? 1'($urandom % 2) : 1'b0;
            if (wr_valid && wr_ready && wn < 4) begin wa[wn] = wr_addr; wd[wn] = wr_data; wn++; end
            else if (wr_valid && wr_ready) wn++;
            rd_ready = rd_valid ? 1'($urandom % 2) : 1'b0;
            rd_data  = rd_ready ? vec_of(rd_addr) : 32'hDEAD_BEEF;
            if (rd_valid && rd_ready) begin ra = rd_addr; rn++; end
            if (bsr_wr_en && bpc_wr_en) begin b_sr = bsr_out; b_pc = bpc_out; bn++; end
            if (pc_load) begin
                seen = 1'b1; f_sr = sr_out; f_isp = isp_out; f_pc = pc_out; f_ispen = isp_wr_en;
                if (!sr_wr_en) f_sr = ~f_sr;
            end
            if (noise && !seen) begin
                req_valid = 1'($urandom % 2); req_kind = 2'($urandom); req_level = 4'($urandom);
                req_index = 8'($urandom); req_restart = 1'($urandom);
                sr_in = $urandom; pc_cur = $urandom; pc_next = $urandom;
                isp_in = $urandom & ~32'd3; vbase_in = $urandom & ~32'd3; fvec_in = $urandom;
            end else begin
                req_valid = 1'b0;
            end
        end
        wr_ready = 1'b0; rd_ready = 1'b0;
        chk("R9", "redirect seen", 32'(seen), 32'd1);
        chk("R1", "busy during entry", 32'(bsy_bad), 32'd0);
        chk("R6", "new status word", f_sr, exp_sr(s, k, lvl));
        if (k == 2'd1) begin
            chk("R3", "write count", 32'(wn), 32'd0);
            chk("R3", "read count", 32'(rn), 32'd0);
            chk("R3", "backup pulses", 32'(bn), 32'd1);
            chk("R3", "backup status", b_sr, s);
            chk("R4", "backup pc", b_pc, rpc);
            chk("R3", "isp untouched", 32'(f_ispen), 32'd0);
            chk("R3", "fast handler", f_pc, fv);
        end else begin
            chk("R2", "write count", 32'(wn), 32'd2);
            chk("R3", "backup pulses", 32'(bn), 32'd0);
            if (wn == 2) begin
                chk("R2", "push1 addr", wa[0], sp - 32'd4);
                chk("R2", "push1 data", wd[0], s);
                chk("R2", "push2 addr", wa[1], sp - 32'd8);
                chk(k == 2'd0 ? "R4" : "R5", "push2 pc", wd[1], rpc);
            end
            chk("R7", "read count", 32'(rn), 32'd1);
            chk("R7", "vector addr", ra, exp_vaddr(k, vb, ix));
            chk("R2", "isp write", 32'(f_ispen), 32'd1);
            chk("R2", "isp value", f_isp, sp - 32'd8);
            chk("R9", "handler pc", f_pc, vec_of(exp_vaddr(k, vb, ix)));
        end
        @(negedge clk);
        chk("R1", "idle after redirect", {29'd0, busy, wr_valid, rd_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", {26'd0, busy, wr_valid, rd_valid, bsr_wr_en, pc_load, sr_wr_en}, 32'd0);
        rst_n = 1'b1;
        // directed corner cases
        run_one(2'd0, 4'd7,  8'd0,   1'b1, 32'hFFFF_FFFF, 32'h100, 32'h104, 32'h2000, 32'h8000, 32'h0, 1'b0); // R4 restart
        run_one(2'd0, 4'd15, 8'd255, 1'b0, 32'h0F13_0000, 32'h100, 32'h104, 32'h2000, 32'hFFFF_FF00, 32'h0, 1'b0); // R7 max index, wrap
        run_one(2'd1, 4'd3,  8'd9,   1'b1, 32'hFFFF_FFFF, 32'h200, 32'h203, 32'h3000, 32'h8000, 32'hCAFE_0000, 1'b0); // R3, R4
        run_one(2'd1, 4'd0,  8'd9,   1'b0, 32'h0001_0000, 32'h200, 32'h203, 32'h3000, 32'h8000, 32'h1234_5678, 1'b0);
        run_one(2'd2, 4'd9,  8'd64,  1'b1, 32'hFFFF_FFFF, 32'h300, 32'h302, 32'h0000_0004, 32'h4000, 32'h0, 1'b0); // R5 ignores restart, isp wrap
        run_one(2'd3, 4'd9,  8'd77,  1'b1, 32'h0A12_0000, 32'h400, 32'h401, 32'h5000, 32'h6000, 32'h0, 1'b0); // R7 break uses base
        for (int i = 0; i < 60; i++) begin
            run_one(2'($urandom), 4'($urandom), 8'($urandom), 1'($urandom), $urandom, $urandom,
                    $urandom, $urandom & ~32'd3, $urandom & ~32'd3, $urandom, 1'b1);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule